// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Generator

This block produces two pulse-width modulated outputs from one system clock. Each channel divides the clock through a selectable prescaler and counts a programmable number of prescaled ticks per period. It holds its output at the active level for a programmable number of those ticks. The active level can be high or low. One shared control word carries a 10-bit field for each channel at a 15-bit stride, and each channel also has its own period/duty word.

Period/duty writes land in a shadow copy, and a per-channel ready flag shows that the copy is pending. A running channel takes the new values only when its current period ends, so its waveform never has a torn period. A channel that is not counting takes them on the next clock. A pulse mode lets software request exactly one period and then leaves the output idle.

Top module: `pwm_dual`

## Requirements
- R1: After reset the control word reads zero, and every output sits at its inactive level, which is high because the active-state bit resets to 0.
- R2: The control word is at word address 0 and channel n's period/duty word is at address 1+n. Channel n's field starts at bit 15n and holds: [3:0] prescaler code, [4] enable, [5] active-high, [6] clock gate, [7] pulse mode, [8] pulse start, [9] force divide-by-1. The ready flag of channel n reads at bit 28+n. In the period/duty word, [31:16] holds the period minus one and [15:0] holds the duty. A read of a period/duty word returns the last value written.
- R3: A running channel repeats a period of (period field + 1) prescaled ticks. It is active during the first duty ticks of each period.
- R4: With the active-high bit at 1 the active level is high. With it at 0 the output is inverted.
- R5: A channel counts only while both enable and clock gate are 1. Otherwise its output is at the inactive level.
- R6: Prescaler code 15 (when bypass is built in) or bit 9 gives one tick per clock. Codes 0..4 divide by 120, 180, 240, 360 and 480. Codes 8..12 divide by 12000, 24000, 36000, 48000 and 72000. Codes 5, 6, 7, 13 and 14 are invalid and keep the channel stopped.
- R7: A period/duty write sets the channel's ready flag. A counting channel copies the shadow into use at the end of its current period, and the flag then clears.
- R8: While a channel is not counting, a pending shadow is copied on the next clock and the ready flag clears.
- R9: A duty of at least period+1 ticks keeps the output active. A duty of 0 keeps it inactive.
- R10: In pulse mode the channel idles at the inactive level. Setting the pulse-start bit produces one period (active for the duty ticks), after which the bit clears itself and the output returns to inactive.
- R11: The prescaler count restarts from zero whenever a channel stops, so a restart begins with a full first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 2 | Channel outputs |

## Verification
The hardest case is a period/duty update that arrives in the middle of a running period. The new values must take effect exactly at the period boundary and not at the write. The stimulus reaches this case by counting clocks from the enabling write so that the update lands at a known counter phase. The scoreboard then expects the old waveform up to that boundary and the new one after it, while the ready flag is sampled on either side of the boundary. A second case that is hard to reach is a restart partway through a divided tick. The bench stops the channel 50 clocks into a 120-clock tick and expects a full 120-clock first tick after the restart.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int unsigned FLD_W = 10;
  localparam int unsigned PRE_W = 17;

  typedef struct packed {
    logic       div1;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act;
    logic       en;
    logic [3:0] code;
  } ch_ctrl_t;

  // 0 marks an invalid code
  function automatic logic [PRE_W-1:0] pre_div(input logic [3:0] code);
    case (code)
      4'd0:    pre_div = PRE_W'(120);
      4'd1:    pre_div = PRE_W'(180);
      4'd2:    pre_div = PRE_W'(240);
      4'd3:    pre_div = PRE_W'(360);
      4'd4:    pre_div = PRE_W'(480);
      4'd8:    pre_div = PRE_W'(12000);
      4'd9:    pre_div = PRE_W'(24000);
      4'd10:   pre_div = PRE_W'(36000);
      4'd11:   pre_div = PRE_W'(48000);
      4'd12:   pre_div = PRE_W'(72000);
      default: pre_div = '0;
    endcase
  endfunction
endpackage

// File: rtl/pwm_dual_prescale.sv
module pwm_dual_prescale #(
  parameter int unsigned PRE_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div1_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (div1_i || (cnt_q == div_i - PRE_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
  import pwm_dual_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter bit          HAS_BYPASS = 1'b1,
  localparam int unsigned PD_W      = 2 * CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ch_ctrl_t        ctrl_i,
  input  logic            pd_we_i,
  input  logic [PD_W-1:0] pd_i,
  output logic [PD_W-1:0] pd_sh_o,
  output logic            rdy_o,
  output logic            pulse_done_o,
  output logic            pwm_o
);
  logic [CNT_W-1:0] prd_q, dty_q, prd_sh_q, dty_sh_q, cnt_q;
  logic [PRE_W-1:0] div;
  logic             div1, run, go, tick, eop, load, active, rdy_q;

  assign div  = pre_div(ctrl_i.code);
  assign div1 = ctrl_i.div1 || (HAS_BYPASS && (ctrl_i.code == 4'hF));
  assign run  = ctrl_i.en && ctrl_i.gate && (div1 || (div != '0));
  assign go   = run && (!ctrl_i.mode || ctrl_i.pulse);

  pwm_dual_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (go),
    .div1_i (div1),
    .div_i  (div),
    .tick_o (tick)
  );

  assign eop  = tick && (cnt_q == prd_q);
  assign load = rdy_q && (eop || !go);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_sh_q <= '0;
      dty_sh_q <= '0;
      rdy_q    <= 1'b0;
    end else begin
      if (pd_we_i) {prd_sh_q, dty_sh_q} <= pd_i;
      if (pd_we_i)   rdy_q <= 1'b1;
      else if (load) rdy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
      dty_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) begin
        prd_q <= prd_sh_q;
        dty_q <= dty_sh_q;
      end
      if (!go || eop) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign active       = go && (cnt_q < dty_q);
  assign pwm_o        = ctrl_i.act ? active : !active;
  assign pulse_done_o = eop && ctrl_i.mode;
  assign rdy_o        = rdy_q;
  assign pd_sh_o      = {prd_sh_q, dty_sh_q};
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
  import pwm_dual_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STRIDE     = 15,
  parameter int unsigned RDY_LSB    = 28,
  parameter int unsigned ADDR_W     = 2,
  parameter bit          HAS_BYPASS = 1'b1,
  localparam int unsigned DATA_W    = 2 * CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  ch_ctrl_t [NUM_CH-1:0]              ctrl_q;
  logic     [NUM_CH-1:0]              rdy, pulse_done, pd_we;
  logic     [NUM_CH-1:0][DATA_W-1:0]  pd_sh;
  logic                               ctrl_we;

  assign ctrl_we = we_i && (addr_i == '0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign pd_we[n] = we_i && (addr_i == ADDR_W'(n + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            ctrl_q[n] <= '0;
      else if (ctrl_we)       ctrl_q[n] <= ch_ctrl_t'(wdata_i[n*STRIDE +: FLD_W]);
      else if (pulse_done[n]) ctrl_q[n].pulse <= 1'b0;
    end

    pwm_dual_chan #(.CNT_W(CNT_W), .HAS_BYPASS(HAS_BYPASS)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_i       (ctrl_q[n]),
      .pd_we_i      (pd_we[n]),
      .pd_i         (wdata_i),
      .pd_sh_o      (pd_sh[n]),
      .rdy_o        (rdy[n]),
      .pulse_done_o (pulse_done[n]),
      .pwm_o        (pwm_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      for (int n = 0; n < NUM_CH; n++) begin
        rdata_o[n*STRIDE +: FLD_W] = ctrl_q[n];
        rdata_o[RDY_LSB + n]       = rdy[n];
      end
    end else begin
      for (int n = 0; n < NUM_CH; n++)
        if (addr_i == ADDR_W'(n + 1)) rdata_o = pd_sh[n];
    end
  end
endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk
  import pwm_dual_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input ch_ctrl_t [NUM_CH-1:0] ctrl_q,
  input logic [NUM_CH-1:0]    rdy,
  input logic [NUM_CH-1:0]    pwm_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    AST_READY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rdy[n]) |-> $past(we_i && (addr_i == ADDR_W'(n + 1)))); // R7

    AST_STOPPED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdy[n] && !(ctrl_q[n].en && ctrl_q[n].gate) && !(we_i && (addr_i == ADDR_W'(n + 1))))
      |=> !rdy[n]); // R8

    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ctrl_q[n].en && ctrl_q[n].gate) |-> (pwm_o[n] == !ctrl_q[n].act)); // R5

    AST_PULSE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(ctrl_q[n].pulse) && ctrl_q[n].mode && !$past(we_i && (addr_i == '0)))
      |-> (pwm_o[n] == !ctrl_q[n].act)); // R10
  end
endmodule

bind pwm_dual pwm_dual_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .ctrl_q (ctrl_q),
  .rdy    (rdy),
  .pwm_o  (pwm_o)
);

// File: tb/pwm_dual_tb.sv
`timescale 1ns/1ps
module pwm_dual_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  pwm_o;

  int checks = 0;
  int errors = 0;

  typedef struct { int ch; logic val; string req; } exp_t;
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  pwm_dual u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  // monitor: one expected output bit per clock, sampled at the falling edge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwm_o[e.ch] !== e.val) begin
        errors++;
        $display("FAIL %s ch%0d: got %b expected %b", e.req, e.ch, pwm_o[e.ch], e.val);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input logic v, input string req);
    exp_t e;
    e.ch = ch; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #2 d = rdata_o;
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(2'd0, d);
    chk(d == 32'h0, "R1 ctrl", d, 32'h0);
    chk(pwm_o == 2'b11, "R1 pwm", {30'b0, pwm_o}, 32'h3);

    // R8 stopped channel loads shadow next clock; R2 readback
    wr(2'd1, {16'd3, 16'd2});
    addr_i = 2'd0;
    @(negedge clk_i); #1 chk(rdata_o[28] == 1'b1, "R8 ready set", rdata_o, 32'h1 << 28);
    @(negedge clk_i); #1 chk(rdata_o[28] == 1'b0, "R8 ready clear", rdata_o, 32'h0);
    rd(2'd1, d);
    chk(d == {16'd3, 16'd2}, "R2 pd readback", d, {16'd3, 16'd2});

    // R3 basic waveform, R7 mid-period update
    wr(2'd0, 32'h0000_007F);
    for (int k = 0; k < 16; k++)
      push(0, (k < 8) ? ((k % 4) < 2) : (((k - 8) % 2) == 0), (k < 8) ? "R3" : "R7");
    repeat (5) @(negedge clk_i);
    wr(2'd1, {16'd1, 16'd1});
    addr_i = 2'd0;
    @(negedge clk_i); #1 chk(rdata_o[28] == 1'b1, "R7 pending", rdata_o[28], 1);
    @(negedge clk_i); #1 chk(rdata_o[28] == 1'b1, "R7 pending at end", rdata_o[28], 1);
    @(negedge clk_i); #1 chk(rdata_o[28] == 1'b0, "R7 loaded", rdata_o[28], 0);
    drain();

    // R5 enable off, gate off
    wr(2'd0, 32'h0000_006F);
    for (int k = 0; k < 4; k++) push(0, 1'b0, "R5 enable");
    drain();
    wr(2'd0, 32'h0000_003F);
    for (int k = 0; k < 4; k++) push(0, 1'b0, "R5 gate");
    drain();

    // R4 inverted polarity on channel 1
    wr(2'd2, {16'd2, 16'd1});
    wr(2'd0, 32'h5F << 15);
    for (int k = 0; k < 9; k++) push(1, ((k % 3) < 1) ? 1'b0 : 1'b1, "R4");
    drain();

    // R9 duty extremes
    wr(2'd0, 32'h0000_006F);
    wr(2'd1, {16'd2, 16'd5});
    wr(2'd0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) push(0, 1'b1, "R9 full");
    drain();
    wr(2'd0, 32'h0000_006F);
    wr(2'd1, {16'd2, 16'd0});
    wr(2'd0, 32'h0000_007F);
    for (int k = 0; k < 8; k++) push(0, 1'b0, "R9 zero");
    drain();

    // R6 invalid code
    wr(2'd0, 32'h0000_006F);
    wr(2'd1, {16'd1, 16'd1});
    wr(2'd0, 32'h0000_0075);
    for (int k = 0; k < 10; k++) push(0, 1'b0, "R6 invalid");
    drain();

    // R6 divide by 120
    wr(2'd0, 32'h0000_0070);
    for (int k = 0; k < 480; k++) push(0, ((k / 120) % 2) == 0, "R6 div120");
    drain();

    // R6 forced divide-by-1
    wr(2'd0, 32'h0000_0030);
    wr(2'd0, 32'h0000_0270);
    for (int k = 0; k < 6; k++) push(0, (k % 2) == 0, "R6 div1");
    drain();

    // R10 single pulse
    wr(2'd0, 32'h0000_0030);
    wr(2'd1, {16'd3, 16'd2});
    wr(2'd0, 32'h0000_00FF);
    for (int k = 0; k < 4; k++) push(0, 1'b0, "R10 idle");
    drain();
    wr(2'd0, 32'h0000_01FF);
    for (int k = 0; k < 8; k++) push(0, k < 2, "R10 pulse");
    drain();
    rd(2'd0, d);
    chk(d[8:7] == 2'b01, "R10 self-clear", {30'b0, d[8:7]}, 32'h1);

    // R11 prescaler restarts after stop
    wr(2'd0, 32'h0000_0030);
    wr(2'd1, {16'd1, 16'd1});
    wr(2'd0, 32'h0000_0070);
    repeat (50) @(negedge clk_i);
    wr(2'd0, 32'h0000_0030);
    wr(2'd0, 32'h0000_0070);
    for (int k = 0; k < 121; k++) push(0, k < 120, "R11");
    drain();

    finish_run();
  end
endmodule